// File: doc/BRIEF.md
# Camera Serial Receiver Control Registers

This block is the software-visible control store of a serial camera receiver. A 32-bit register bus with separate read and write strobes reaches four writable registers: global control, PHY control, stream configuration and frame resolution. A fifth read-only word shows the configuration that the receiver core is using at the moment.

Stream configuration is double-buffered. Software first writes the data-type code, lane count, frame size, output alignment and clock source into pending registers. These values reach the core outputs only when software sets the shadow-update bit. The global enable, lane polarity swap and settle count act directly. The lane enables sent to the core are the software lane-enable bits, limited to a contiguous mask of the clock lane plus the active data lanes. A soft-reset bit produces a one-cycle pulse for the core. The pulse also empties the active configuration and drops the enable.

Top module: `csirx_ctrl_regs`

## Requirements
- R1: After the synchronous reset, every core output is 0, `soft_rst_o` is 0 and every register reads as 0.
- R2: The control register sits at byte offset 0x00. Bit 31 (polarity swap), bit 20 (32-bit alignment, 0 meaning 24-bit), bit 8 (external clock) and bit 0 (enable) read back as written. Bits 16 and 4 always read as 0. `swap_o` and `en_o` follow their bits on the clock edge that takes the write.
- R3: The PHY control register sits at offset 0x04. Bits 31:27 hold the settle count and bits 4:0 hold the lane-enable bits, and both read back. `settle_o` follows the write on the clock edge that takes it.
- R4: The configuration register sits at offset 0x08. Bits 7:2 hold the 6-bit data-type code and bits 1:0 hold the lane count minus one, and both read back.
- R5: The resolution register sits at offset 0x2C. Bits 31:16 hold the width and bits 15:0 the height, and both read back.
- R6: `fmt_o`, `lanes_o`, `width_o`, `height_o`, `align_o` and `extclk_o` keep their values until a control write with bit 16 set. They take the pending values one clock edge after the edge that took that write, including values written in that same write.
- R7: A read of offset 0x38 returns the active configuration: the data-type code in bits 7:2, lanes minus one in bits 1:0 and zeros above.
- R8: `lane_en_o` equals the PHY lane-enable bits ANDed with a mask whose low (`lanes_o`+2) bits are set, while the enable is on, and is 0 while it is off. It is registered one edge after its inputs.
- R9: A control write with bit 4 set makes `soft_rst_o` high for exactly the next cycle. On the following edge the active configuration and the enable clear, and the pending registers keep their values. If bit 16 is set in the same write, the reset wins.
- R10: A read of any offset other than 0x00, 0x04, 0x08, 0x2C and 0x38 returns 0. A write to such an offset changes no register and no output.
- R11: `rdata_o` is registered. It shows the addressed word on the cycle after a cycle with `rd_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| en_o | output | 1 | Receiver enable |
| swap_o | output | 1 | Lane polarity swap |
| extclk_o | output | 1 | Active clock-source select (1 = external) |
| align_o | output | 1 | Active output alignment (1 = 32-bit) |
| settle_o | output | 5 | High-speed receive settle count |
| lane_en_o | output | 5 | Clock and data lane enables |
| fmt_o | output | 6 | Active data-type code |
| lanes_o | output | 2 | Active lane count minus one |
| width_o | output | 16 | Active frame width |
| height_o | output | 16 | Active frame height |
| soft_rst_o | output | 1 | One-cycle soft-reset pulse to the core |

## Verification
Several properties are checked on every cycle. The active outputs never move without an update or reset pulse, and a reset pulse always leaves the active set and the enable at zero. The lane enables never reach above the clock lane plus the active data lanes, and drop the cycle after the enable goes off. Unmapped reads and the self-clearing control bits read as zero. Only the bench's scenarios can show the values themselves: that pending values reach the core at the right cycle, that reset beats update in one write, that pending registers survive a soft reset, and that unmapped writes leave everything intact.

// File: rtl/csirx_pkg.sv
package csirx_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned FMT_W     = 6;
  localparam int unsigned NLANE_W   = 2;
  localparam int unsigned DIM_W     = 16;
  localparam int unsigned SETTLE_W  = 5;
  localparam int unsigned LANE_W    = 5;

  localparam int unsigned OFS_CTRL   = 'h00;
  localparam int unsigned OFS_PHY    = 'h04;
  localparam int unsigned OFS_CFG    = 'h08;
  localparam int unsigned OFS_RES    = 'h2C;
  localparam int unsigned OFS_ACTCFG = 'h38;

  localparam int unsigned CB_SWAP  = 31;
  localparam int unsigned CB_ALIGN = 20;
  localparam int unsigned CB_UPD   = 16;
  localparam int unsigned CB_EXT   = 8;
  localparam int unsigned CB_RST   = 4;
  localparam int unsigned CB_EN    = 0;
  localparam int unsigned PB_SETTLE = REG_W - SETTLE_W;
  localparam int unsigned FMT_LO   = NLANE_W;

  typedef struct packed {
    logic [FMT_W-1:0]   fmt;
    logic [NLANE_W-1:0] lanes;
    logic [DIM_W-1:0]   width;
    logic [DIM_W-1:0]   height;
    logic               align32;
    logic               ext_clk;
  } stream_cfg_t;
endpackage

// File: rtl/csirx_pending_regs.sv
module csirx_pending_regs
  import csirx_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wdata,
  output stream_cfg_t         pend_o,
  output logic                swap_o,
  output logic                en_o,
  output logic [SETTLE_W-1:0] settle_o,
  output logic [LANE_W-1:0]   lane_bits_o,
  output logic                upd_pulse_o,
  output logic                rst_pulse_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o      <= '0;
      swap_o      <= 1'b0;
      en_o        <= 1'b0;
      settle_o    <= '0;
      lane_bits_o <= '0;
      upd_pulse_o <= 1'b0;
      rst_pulse_o <= 1'b0;
    end else begin
      upd_pulse_o <= 1'b0;
      rst_pulse_o <= 1'b0;
      if (rst_pulse_o) en_o <= 1'b0;
      if (wr_en) begin
        if (addr == ADDR_W'(OFS_CTRL)) begin
          swap_o         <= wdata[CB_SWAP];
          pend_o.align32 <= wdata[CB_ALIGN];
          pend_o.ext_clk <= wdata[CB_EXT];
          if (!rst_pulse_o) en_o <= wdata[CB_EN];
          upd_pulse_o    <= wdata[CB_UPD];
          rst_pulse_o    <= wdata[CB_RST];
        end else if (addr == ADDR_W'(OFS_PHY)) begin
          settle_o    <= wdata[REG_W-1:PB_SETTLE];
          lane_bits_o <= wdata[LANE_W-1:0];
        end else if (addr == ADDR_W'(OFS_CFG)) begin
          pend_o.fmt   <= wdata[FMT_LO +: FMT_W];
          pend_o.lanes <= wdata[NLANE_W-1:0];
        end else if (addr == ADDR_W'(OFS_RES)) begin
          pend_o.width  <= wdata[REG_W-1:DIM_W];
          pend_o.height <= wdata[DIM_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/csirx_active_regs.sv
module csirx_active_regs
  import csirx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        upd,
  input  stream_cfg_t pend_i,
  output stream_cfg_t act_o
);
  always_ff @(posedge clk) begin
    if (rst || clr) act_o <= '0;
    else if (upd)   act_o <= pend_i;
  end
endmodule

// File: rtl/csirx_lane_mask.sv
module csirx_lane_mask #(
  parameter int unsigned LANE_W  = 5,
  parameter int unsigned NLANE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [LANE_W-1:0]  lane_bits,
  input  logic [NLANE_W-1:0] lanes_m1,
  output logic [LANE_W-1:0]  lane_en_o
);
  localparam int unsigned TOP_IDX_OFS = 1;
  logic [LANE_W-1:0] thermo;

  for (genvar i = 0; i < LANE_W; i++) begin : g_thermo
    assign thermo[i] = (int'(lanes_m1) + TOP_IDX_OFS) >= i;
  end

  always_ff @(posedge clk) begin
    if (rst)     lane_en_o <= '0;
    else if (en) lane_en_o <= lane_bits & thermo;
    else         lane_en_o <= '0;
  end
endmodule

// File: rtl/csirx_ctrl_regs.sv
module csirx_ctrl_regs
  import csirx_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  input  logic                rd_en,
  output logic [31:0]         rdata_o,
  output logic                en_o,
  output logic                swap_o,
  output logic                extclk_o,
  output logic                align_o,
  output logic [4:0]          settle_o,
  output logic [4:0]          lane_en_o,
  output logic [5:0]          fmt_o,
  output logic [1:0]          lanes_o,
  output logic [15:0]         width_o,
  output logic [15:0]         height_o,
  output logic                soft_rst_o
);
  stream_cfg_t           pend, act;
  logic [LANE_W-1:0]     lane_bits;
  logic                  upd_pulse;
  logic [REG_W-1:0]      rd_word;

  csirx_pending_regs #(.ADDR_W(ADDR_W)) pend_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pend_o(pend), .swap_o(swap_o), .en_o(en_o), .settle_o(settle_o),
    .lane_bits_o(lane_bits), .upd_pulse_o(upd_pulse), .rst_pulse_o(soft_rst_o)
  );

  csirx_active_regs act_i (
    .clk(clk), .rst(rst), .clr(soft_rst_o), .upd(upd_pulse),
    .pend_i(pend), .act_o(act)
  );

  csirx_lane_mask #(.LANE_W(LANE_W), .NLANE_W(NLANE_W)) mask_i (
    .clk(clk), .rst(rst), .en(en_o), .lane_bits(lane_bits),
    .lanes_m1(act.lanes), .lane_en_o(lane_en_o)
  );

  assign fmt_o    = act.fmt;
  assign lanes_o  = act.lanes;
  assign width_o  = act.width;
  assign height_o = act.height;
  assign align_o  = act.align32;
  assign extclk_o = act.ext_clk;

  always_comb begin
    rd_word = '0;
    if (addr == ADDR_W'(OFS_CTRL)) begin
      rd_word[CB_SWAP]  = swap_o;
      rd_word[CB_ALIGN] = pend.align32;
      rd_word[CB_EXT]   = pend.ext_clk;
      rd_word[CB_EN]    = en_o;
    end else if (addr == ADDR_W'(OFS_PHY)) begin
      rd_word[REG_W-1:PB_SETTLE] = settle_o;
      rd_word[LANE_W-1:0]        = lane_bits;
    end else if (addr == ADDR_W'(OFS_CFG)) begin
      rd_word[FMT_LO +: FMT_W]  = pend.fmt;
      rd_word[NLANE_W-1:0]      = pend.lanes;
    end else if (addr == ADDR_W'(OFS_RES)) begin
      rd_word = {pend.width, pend.height};
    end else if (addr == ADDR_W'(OFS_ACTCFG)) begin
      rd_word[FMT_LO +: FMT_W]  = act.fmt;
      rd_word[NLANE_W-1:0]      = act.lanes;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_word;
  end
endmodule

// File: rtl/csirx_ctrl_regs_chk.sv
module csirx_ctrl_regs_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              rd_en,
  input logic [31:0]       rdata_o,
  input logic              en_o,
  input logic              extclk_o,
  input logic              align_o,
  input logic [4:0]        lane_en_o,
  input logic [5:0]        fmt_o,
  input logic [1:0]        lanes_o,
  input logic [15:0]       width_o,
  input logic [15:0]       height_o,
  input logic              soft_rst_o,
  input logic              upd_pulse
);
  logic mapped;
  assign mapped = (addr == ADDR_W'('h00)) || (addr == ADDR_W'('h04)) ||
                  (addr == ADDR_W'('h08)) || (addr == ADDR_W'('h2C)) ||
                  (addr == ADDR_W'('h38));

  a_r6_active_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(upd_pulse) && !$past(soft_rst_o)) |->
      ($stable(fmt_o) && $stable(lanes_o) && $stable(width_o) &&
       $stable(height_o) && $stable(align_o) && $stable(extclk_o)));

  a_r9_clear_after_pulse: assert property (@(posedge clk) disable iff (rst)
    $past(soft_rst_o) |->
      (fmt_o == '0 && lanes_o == '0 && width_o == '0 && height_o == '0 && !en_o));

  a_r9_pulse_source: assert property (@(posedge clk) disable iff (rst)
    soft_rst_o |-> $past(wr_en && addr == ADDR_W'('h00) && wdata[4]));

  a_r8_lane_bound: assert property (@(posedge clk) disable iff (rst)
    ((32'(lane_en_o) >> (int'($past(lanes_o)) + 2)) == 32'd0));

  a_r8_lane_off: assert property (@(posedge clk) disable iff (rst)
    !en_o |=> (lane_en_o == '0));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && !mapped) |-> (rdata_o == 32'd0));

  a_r2_selfclr_bits: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && addr == ADDR_W'('h00)) |-> (!rdata_o[16] && !rdata_o[4]));
endmodule

bind csirx_ctrl_regs csirx_ctrl_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rd_en(rd_en), .rdata_o(rdata_o), .en_o(en_o), .extclk_o(extclk_o),
  .align_o(align_o), .lane_en_o(lane_en_o), .fmt_o(fmt_o), .lanes_o(lanes_o),
  .width_o(width_o), .height_o(height_o), .soft_rst_o(soft_rst_o),
  .upd_pulse(upd_pulse)
);

// File: tb/csirx_ctrl_regs_tb_top.sv
module csirx_ctrl_regs_tb_top;
  localparam int unsigned ADDR_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_o;
  logic en_o, swap_o, extclk_o, align_o, soft_rst_o;
  logic [4:0] settle_o, lane_en_o;
  logic [5:0] fmt_o;
  logic [1:0] lanes_o;
  logic [15:0] width_o, height_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  csirx_ctrl_regs #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .rdata_o(rdata_o), .en_o(en_o), .swap_o(swap_o),
    .extclk_o(extclk_o), .align_o(align_o), .settle_o(settle_o),
    .lane_en_o(lane_en_o), .fmt_o(fmt_o), .lanes_o(lanes_o),
    .width_o(width_o), .height_o(height_o), .soft_rst_o(soft_rst_o)
  );

  // reference model
  logic p_swap, p_align, p_ext, m_en;
  logic [4:0] p_settle, p_lane;
  logic [5:0] p_fmt;
  logic [1:0] p_lanes;
  logic [15:0] p_w, p_h;
  logic a_align, a_ext;
  logic [5:0] a_fmt;
  logic [1:0] a_lanes;
  logic [15:0] a_w, a_h;

  task automatic model_reset();
    p_swap = 0; p_align = 0; p_ext = 0; m_en = 0;
    p_settle = 0; p_lane = 0; p_fmt = 0; p_lanes = 0; p_w = 0; p_h = 0;
    a_align = 0; a_ext = 0; a_fmt = 0; a_lanes = 0; a_w = 0; a_h = 0;
  endtask

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h00: begin
        p_swap = d[31]; p_align = d[20]; p_ext = d[8]; m_en = d[0];
        if (d[4]) begin
          m_en = 0; a_align = 0; a_ext = 0; a_fmt = 0; a_lanes = 0; a_w = 0; a_h = 0;
        end else if (d[16]) begin
          a_align = p_align; a_ext = p_ext; a_fmt = p_fmt; a_lanes = p_lanes;
          a_w = p_w; a_h = p_h;
        end
      end
      8'h04: begin p_settle = d[31:27]; p_lane = d[4:0]; end
      8'h08: begin p_fmt = d[7:2]; p_lanes = d[1:0]; end
      8'h2C: begin p_w = d[31:16]; p_h = d[15:0]; end
      default: ;
    endcase
  endtask

  function automatic logic [4:0] exp_lane_en();
    logic [4:0] th;
    for (int i = 0; i < 5; i++) th[i] = (i <= int'(a_lanes) + 1);
    return m_en ? (p_lane & th) : 5'd0;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      8'h00: begin r[31] = p_swap; r[20] = p_align; r[8] = p_ext; r[0] = m_en; end
      8'h04: begin r[31:27] = p_settle; r[4:0] = p_lane; end
      8'h08: begin r[7:2] = p_fmt; r[1:0] = p_lanes; end
      8'h2C: r = {p_w, p_h};
      8'h38: begin r[7:2] = a_fmt; r[1:0] = a_lanes; end
      default: ;
    endcase
    return r;
  endfunction

  function automatic bit is_mapped(input logic [7:0] a);
    return a == 8'h00 || a == 8'h04 || a == 8'h08 || a == 8'h2C || a == 8'h38;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    pulse_write(a, d);
    model_write(a, d);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] r);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; r = rdata_o;
  endtask

  task automatic check_outputs();
    check("R2 en_o", 32'(en_o), 32'(m_en));
    check("R2 swap_o", 32'(swap_o), 32'(p_swap));
    check("R3 settle_o", 32'(settle_o), 32'(p_settle));
    check("R8 lane_en_o", 32'(lane_en_o), 32'(exp_lane_en()));
    check("R6 fmt/lanes", {24'd0, fmt_o, lanes_o}, {24'd0, a_fmt, a_lanes});
    check("R6 width/height", {width_o, height_o}, {a_w, a_h});
    check("R6 align/extclk", {30'd0, align_o, extclk_o}, {30'd0, a_align, a_ext});
    check("R9 soft_rst_o idle", 32'(soft_rst_o), 32'd0);
  endtask

  task automatic check_reads(input string tag);
    logic [31:0] r;
    logic [7:0] list [6] = '{8'h00, 8'h04, 8'h08, 8'h2C, 8'h38, 8'h10};
    foreach (list[i]) begin
      do_read(list[i], r);
      check($sformatf("R11 %s read %h", tag, list[i]), r, exp_read(list[i]));
    end
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 en_o", 32'(en_o), 0);
    check("R1 lane_en_o", 32'(lane_en_o), 0);
    check("R1 cfg outputs", {fmt_o, lanes_o, width_o, height_o, align_o, extclk_o, soft_rst_o}, 0);
    check_reads("R1");

    // R4 R5 R3: pending registers and readback, outputs held (R6)
    do_write(8'h08, 32'hFFFF_FFB7);   // fmt 0x2D? -> bits7:2 = 101101, lanes 3
    do_write(8'h08, {24'd0, 6'h2B, 2'd3}); // RAW10, 4 lanes
    do_write(8'h2C, {16'd1920, 16'd1080});
    do_write(8'h04, {5'd13, 22'd0, 5'h1F});
    check_outputs();
    check_reads("R4 R5");

    // R6 timing: update with alignment and enable
    pulse_write(8'h00, 32'h0011_0101);
    check("R6 not yet fmt", 32'(fmt_o), 32'(a_fmt));
    check("R2 en immediate", 32'(en_o), 1);
    model_write(8'h00, 32'h0011_0101);
    @(negedge clk);
    check("R6 fmt after update", 32'(fmt_o), 32'h2B);
    check("R6 width after update", 32'(width_o), 32'd1920);
    @(negedge clk);
    check_outputs();
    check_reads("R7 R2");

    // R8 fewer lanes narrows the mask
    do_write(8'h08, {24'd0, 6'h2A, 2'd0});
    do_write(8'h00, 32'h0001_0001);
    check("R8 one lane mask", 32'(lane_en_o), 32'h03);
    check_outputs();

    // R9 soft reset with simultaneous update: reset wins, pending kept
    pulse_write(8'h00, 32'h0001_0011);
    check("R9 pulse high", 32'(soft_rst_o), 1);
    model_write(8'h00, 32'h0001_0011);
    @(negedge clk);
    check("R9 pulse one cycle", 32'(soft_rst_o), 0);
    check("R9 active cleared", {fmt_o, lanes_o, width_o, height_o}, 0);
    check("R9 enable cleared", 32'(en_o), 0);
    @(negedge clk);
    check_outputs();
    check_reads("R9");

    // R10 unmapped write ignored
    do_write(8'h0C, 32'hFFFF_FFFF);
    do_write(8'h39, 32'hFFFF_FFFF);
    check_outputs();
    check_reads("R10");

    // random mix
    for (int it = 0; it < 60; it++) begin
      logic [7:0] a;
      logic [31:0] d;
      int sel;
      sel = int'($urandom % 7);
      case (sel)
        0, 1: a = 8'h00;
        2: a = 8'h04;
        3: a = 8'h08;
        4: a = 8'h2C;
        5: a = 8'h38;
        default: begin
          a = 8'($urandom);
          while (is_mapped(a)) a = 8'($urandom);
        end
      endcase
      d = $urandom;
      if (a == 8'h00 && ($urandom % 6) != 0) d[4] = 1'b0;
      do_write(a, d);
      check_outputs();
      if (it % 5 == 0) check_reads(is_mapped(a) ? "R6 R7" : "R10");
      else begin
        do_read(a, r);
        check($sformatf("R11 rand read %h", a), r, exp_read(a));
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule